// File: doc/BRIEF.md
# Output Compare and PWM Channel

This block is the output half of one timer channel. Each cycle it compares an externally supplied counter value with an active compare value. Depending on a 3-bit mode field, it drives a registered, active-high reference waveform. The mode field selects frozen, set-on-match, clear-on-match, toggle-on-match, forced low, forced high, or one of two direction-aware PWM shapes. The pin level is the reference passed through a polarity inversion.

The compare value is written through a write strobe. When the preload option is off, the write reaches the active compare register directly. When it is on, the write lands in a holding register. That holding register is copied to the active register only when an update-event pulse arrives.

A sticky match flag is raised by an equality match or by a software compare strobe, and is cleared by a clear strobe. The counter itself lives outside the block. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the reference is 0, the flag is 0 and the active compare value is 0, so the pin equals the polarity input.
- R2: With mode 3'b000 (frozen), the reference keeps its value whatever the counter does.
- R3: With mode 3'b001, a match (counter equal to the active compare value) makes the reference 1 one cycle later. With mode 3'b010, a match makes it 0 one cycle later. Without a match it holds.
- R4: With mode 3'b011, each match cycle inverts the reference one cycle later.
- R5: Mode 3'b100 forces the reference to 0 and mode 3'b101 forces it to 1, one cycle later.
- R6: Mode 3'b110 computes a level. When the direction input is 0 (up), the level is 1 when counter < compare and 0 otherwise. When the direction input is 1 (down), the level is 0 when counter > compare and 1 otherwise.
- R7: Mode 3'b111 uses the inverse of the R6 level in both directions.
- R8: In the PWM modes, the reference takes the level only in two cases: in a cycle where the comparison result differs from the previous cycle's result, or in a cycle whose preceding cycle had mode 3'b000. Otherwise it holds. The mode that precedes the first cycle after reset counts as 3'b000.
- R9: With preload disabled, a compare write becomes the active compare value in the next cycle.
- R10: With preload enabled, a compare write only loads the holding register. The active compare value is unchanged except on an update pulse, which copies the holding register's prior content into it.
- R11: The flag is set by a match in any mode, or by the software compare strobe. It is cleared by the clear strobe, and setting wins over clearing. Otherwise it holds.
- R12: The pin equals the reference XOR the polarity input, without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Counter value |
| cnt_down_i | input | 1 | Count direction, 1 = down |
| upd_evt_i | input | 1 | Update-event pulse |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 16 | Compare value write data |
| mode_i | input | 3 | Output mode field |
| preload_en_i | input | 1 | Compare preload enable |
| pol_i | input | 1 | Output polarity, 1 = inverted pin |
| sw_cmp_i | input | 1 | Software compare strobe |
| flag_clr_i | input | 1 | Match flag clear strobe |
| ref_o | output | 1 | Reference waveform |
| pin_o | output | 1 | Pin level |
| match_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The assertions watch, on every cycle, the properties that span a single step:
- a frozen reference does not move;
- the forced and set-on-match modes reach their level;
- a direct write reaches the active compare value;
- preload mode keeps the active value still between update pulses;
- the flag is sticky and rises after a strobe.

The PWM shapes in both directions, the hold rule when entering a PWM mode from a non-frozen mode, toggling across repeated matches, and the exact copy timing of the holding register only show up over the bench's scenarios. Those scenarios sweep the counter up and down against a behavioural model.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [2:0] {
    OM_FROZEN = 3'b000,
    OM_SET    = 3'b001,
    OM_CLR    = 3'b010,
    OM_TOGGLE = 3'b011,
    OM_FLOW   = 3'b100,
    OM_FHIGH  = 3'b101,
    OM_PWM_A  = 3'b110,
    OM_PWM_B  = 3'b111
  } ocmp_mode_e;
endpackage

// File: rtl/ocmp_cmp_store.sv
// Compare value storage: holding register plus active register.
module ocmp_cmp_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         preload_en_i,
  input  logic         upd_i,
  output logic [W-1:0] cmp_act_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i) hold_q <= wdata_i;
      if (wr_i && !preload_en_i)
        act_q <= wdata_i;
      else if (upd_i && preload_en_i)
        act_q <= hold_q;
    end
  end

  assign cmp_act_o = act_q;
endmodule

// File: rtl/ocmp_ref_gen.sv
// Reference waveform generator for all eight modes.
module ocmp_ref_gen
  import ocmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic [W-1:0] cmp_i,
  input  logic [2:0]   mode_i,
  output logic         match_o,
  output logic         ref_o
);
  ocmp_mode_e mode;
  ocmp_mode_e prev_mode_q;
  logic       ref_q;
  logic       raw_lvl;
  logic       raw_q;
  logic       pwm_lvl;
  logic       pwm_take;
  logic       ref_d;

  assign mode    = ocmp_mode_e'(mode_i);
  assign match_o = (cnt_i == cmp_i);

  // Level for the first PWM shape; the second shape inverts it.
  always_comb begin
    if (down_i) raw_lvl = !(cnt_i > cmp_i);
    else        raw_lvl = (cnt_i < cmp_i);
  end

  assign pwm_lvl  = (mode == OM_PWM_B) ? !raw_lvl : raw_lvl;
  assign pwm_take = (raw_lvl != raw_q) || (prev_mode_q == OM_FROZEN);

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OM_FROZEN: ref_d = ref_q;
      OM_SET:    if (match_o) ref_d = 1'b1;
      OM_CLR:    if (match_o) ref_d = 1'b0;
      OM_TOGGLE: if (match_o) ref_d = !ref_q;
      OM_FLOW:   ref_d = 1'b0;
      OM_FHIGH:  ref_d = 1'b1;
      OM_PWM_A,
      OM_PWM_B:  if (pwm_take) ref_d = pwm_lvl;
      default:   ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q       <= 1'b0;
      raw_q       <= 1'b0;
      prev_mode_q <= OM_FROZEN;
    end else begin
      ref_q       <= ref_d;
      raw_q       <= raw_lvl;
      prev_mode_q <= mode;
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/ocmp_flag.sv
// Sticky match flag; set has priority over clear.
module ocmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic sw_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (match_i || sw_i)  flag_q <= 1'b1;
    else if (clr_i)            flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         cnt_down_i,
  input  logic         upd_evt_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic [2:0]   mode_i,
  input  logic         preload_en_i,
  input  logic         pol_i,
  input  logic         sw_cmp_i,
  input  logic         flag_clr_i,
  output logic         ref_o,
  output logic         pin_o,
  output logic         match_flag_o
);
  logic [W-1:0] cmp_act;
  logic         match;
  logic         ref_w;

  ocmp_cmp_store #(.W(W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (cmp_wr_i),
    .wdata_i      (cmp_wdata_i),
    .preload_en_i (preload_en_i),
    .upd_i        (upd_evt_i),
    .cmp_act_o    (cmp_act)
  );

  ocmp_ref_gen #(.W(W)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_i   (cnt_i),
    .down_i  (cnt_down_i),
    .cmp_i   (cmp_act),
    .mode_i  (mode_i),
    .match_o (match),
    .ref_o   (ref_w)
  );

  ocmp_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .match_i (match),
    .sw_i    (sw_cmp_i),
    .clr_i   (flag_clr_i),
    .flag_o  (match_flag_o)
  );

  assign ref_o = ref_w;
  assign pin_o = ref_w ^ pol_i;
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt_i,
  input logic         upd_evt_i,
  input logic         cmp_wr_i,
  input logic [W-1:0] cmp_wdata_i,
  input logic [2:0]   mode_i,
  input logic         preload_en_i,
  input logic         sw_cmp_i,
  input logic         flag_clr_i,
  input logic [W-1:0] cmp_act,
  input logic         ref_o,
  input logic         match_flag_o
);
  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b000) |=> $stable(ref_o));

  p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b001 && cnt_i == cmp_act) |=> ref_o);

  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b100) |=> !ref_o);

  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b101) |=> ref_o);

  p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_i && !preload_en_i) |=> (cmp_act == $past(cmp_wdata_i)));

  p_preload_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en_i && !upd_evt_i) |=> $stable(cmp_act));

  p_strobe_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cmp_i |=> match_flag_o);

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag_o && !flag_clr_i) |=> match_flag_o);
endmodule

bind ocmp_channel ocmp_channel_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_i        (cnt_i),
  .upd_evt_i    (upd_evt_i),
  .cmp_wr_i     (cmp_wr_i),
  .cmp_wdata_i  (cmp_wdata_i),
  .mode_i       (mode_i),
  .preload_en_i (preload_en_i),
  .sw_cmp_i     (sw_cmp_i),
  .flag_clr_i   (flag_clr_i),
  .cmp_act      (cmp_act),
  .ref_o        (ref_o),
  .match_flag_o (match_flag_o)
);

// File: tb/ocmp_channel_bench.sv
module ocmp_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        down = 1'b0;
  logic        upd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [2:0]  mode = 3'b000;
  logic        pe = 1'b0;
  logic        pol = 1'b0;
  logic        sw = 1'b0;
  logic        clr = 1'b0;
  logic        ref_w, pin_w, flag_w;

  int checks = 0;
  int errors = 0;
  string req = "R1";

  // behavioural model state
  int m_cmp = 0, m_hold = 0, m_ref = 0, m_flag = 0, m_raw = 0, m_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocmp_channel u_ocmp_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_down_i(down),
    .upd_evt_i(upd), .cmp_wr_i(wr), .cmp_wdata_i(wdata), .mode_i(mode),
    .preload_en_i(pe), .pol_i(pol), .sw_cmp_i(sw), .flag_clr_i(clr),
    .ref_o(ref_w), .pin_o(pin_w), .match_flag_o(flag_w)
  );

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // advance model to the next edge, then compare at the falling edge
  task automatic cyc();
    int raw, lvl, match, nref;
    @(posedge clk);
    match = (int'(cnt) == m_cmp);
    raw = down ? (int'(cnt) > m_cmp ? 0 : 1) : (int'(cnt) < m_cmp ? 1 : 0);
    lvl = (mode == 3'b111) ? 1 - raw : raw;
    nref = m_ref;
    case (mode)
      3'b001: if (match != 0) nref = 1;
      3'b010: if (match != 0) nref = 0;
      3'b011: if (match != 0) nref = 1 - m_ref;
      3'b100: nref = 0;
      3'b101: nref = 1;
      3'b110, 3'b111: if (raw != m_raw || m_prev == 0) nref = lvl;
      default: nref = m_ref;
    endcase
    m_ref = nref;
    m_raw = raw;
    m_prev = int'(mode);
    if (match != 0 || sw) m_flag = 1;
    else if (clr) m_flag = 0;
    if (wr && !pe) m_cmp = int'(wdata);
    else if (upd && pe) m_cmp = m_hold;
    if (wr) m_hold = int'(wdata);
    @(negedge clk);
    check("ref", int'(ref_w), m_ref);
    check("pin", int'(pin_w), m_ref ^ int'(pol));
    check("flag", int'(flag_w), m_flag);
  endtask

  task automatic write_cmp(input int v);
    wr = 1'b1; wdata = 16'(v);
    cyc();
    wr = 1'b0;
  endtask

  task automatic sweep(input int a, input int b);
    if (a <= b) begin
      down = 1'b0;
      for (int i = a; i <= b; i++) begin cnt = 16'(i); cyc(); end
    end else begin
      down = 1'b1;
      for (int i = a; i >= b; i--) begin cnt = 16'(i); cyc(); end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, pin follows polarity
    pol = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("ref", int'(ref_w), 0);
    check("pin", int'(pin_w), 1);
    check("flag", int'(flag_w), 0);
    rst_n = 1'b1;
    cyc();
    pol = 1'b0;

    // R9: direct write, then R3 set/clear on match
    req = "R9"; write_cmp(5);
    req = "R3"; mode = 3'b001; sweep(0, 9);
    clr = 1'b1; cyc(); clr = 1'b0;
    mode = 3'b010; sweep(0, 9);
    // R4: toggle across repeated matches
    req = "R4"; mode = 3'b011; sweep(3, 7); sweep(7, 3); sweep(4, 6);
    // R2: frozen holds through a match
    req = "R2"; mode = 3'b000; sweep(0, 9); sweep(9, 0);
    // R5: forced levels
    req = "R5"; mode = 3'b101; sweep(0, 3); mode = 3'b100; sweep(0, 3);
    // R6: PWM A up and down
    req = "R6"; write_cmp(8); mode = 3'b110; sweep(0, 15); sweep(15, 0);
    // R7: PWM B up and down
    req = "R7"; mode = 3'b111; sweep(0, 15); sweep(15, 0);
    // R8: entering PWM from forced high holds until comparison flips
    req = "R8"; mode = 3'b101; cnt = 12; down = 1'b0; cyc();
    mode = 3'b110; sweep(12, 14); sweep(0, 3);
    mode = 3'b000; cnt = 2; cyc(); mode = 3'b111; sweep(2, 5);
    // R10: preload holds writes until an update pulse
    req = "R10"; pe = 1'b1; mode = 3'b001; clr = 1'b1; cyc(); clr = 1'b0;
    write_cmp(12); sweep(10, 13);
    upd = 1'b1; wr = 1'b1; wdata = 16'd3; cnt = 0; cyc(); wr = 1'b0; upd = 1'b0;
    mode = 3'b011; sweep(10, 13);
    upd = 1'b1; cyc(); upd = 1'b0; sweep(0, 4);
    pe = 1'b0;
    // R11: strobe sets, clear clears, set wins
    req = "R11"; mode = 3'b000; write_cmp(100); cnt = 0;
    clr = 1'b1; cyc(); clr = 1'b0; cyc();
    sw = 1'b1; cyc(); sw = 1'b0; cyc();
    sw = 1'b1; clr = 1'b1; cyc(); sw = 1'b0; cyc(); clr = 1'b0;
    cnt = 100; clr = 1'b1; cyc(); cnt = 0; cyc(); clr = 1'b0;
    // R12: polarity inverts the pin combinationally
    req = "R12"; mode = 3'b101; cyc(); pol = 1'b1; cyc(); mode = 3'b100; cyc();
    pol = 1'b0; cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule